// File: doc/BRIEF.md
# I2C-Mode Serial Receive Event Controller

This block receives bytes from a two-wire serial bus in an I2C-style mode. It conditions the incoming clock and data lines, counts the eight data bits and the acknowledge bit that follows them, and assembles each byte into a 9-bit receive word. Two mode inputs decide which edge of the ninth clock moves the word into the receive buffer, which bit layout the word uses, and which interrupt pulses are raised.

One mode input chooses between acknowledge-style events (an ACK or NACK pulse that reports the sampled acknowledge bit) and transfer-style events (separate receive and transmit pulses). The other chooses between a timing without clock delay, where the bus clock rests high, and a timing with clock delay, where the clock rests low and the buffer is written twice. The buffer is presented as a valid/ready stream. The serial bus cannot be stalled, so the block never applies back-pressure. A new load overwrites a word that has not been taken, and the valid flag then stays high. Any change of the mode inputs restarts bit counting and drops every event that is still pending.

Top module: `i2c_rx_event_ctrl`

## Requirements
- R1: After reset all four interrupt outputs are 0, `rx_valid` is 0 and `sda_out` is 1.
- R2: A level on `scl_in` or `sda_in` is accepted only after it has differed from the accepted level for `filt_len` consecutive cycles (a value of 0 acts as 1). A shorter SCL pulse does not count as a bit.
- R3: The first data bit received goes to `rx_data[7]` and the eighth goes to `rx_data[0]`. Outside the split layout, `rx_data[8]` holds the acknowledge bit.
- R4: With `mode_txrx`=0, the 9th SCL rising edge raises `irq_ack` when the sampled acknowledge bit is 0 and `irq_nack` when it is 1. `irq_rx` and `irq_tx` stay 0.
- R5: With `mode_dly`=0 the buffer is loaded exactly once per byte, at the 9th SCL rising edge.
- R6: With `mode_dly`=1 the buffer is loaded twice per byte, at the rising edge and at the falling edge of the 9th SCL clock.
- R7: With `mode_txrx`=1 and `mode_dly`=1 the word is split. Bits 1 to 7 go to `rx_data[6:0]`, bit 8 goes to `rx_data[8]`, and the acknowledge bit goes to `rx_data[7]`.
- R8: With `mode_txrx`=1, `irq_rx` fires at the 9th SCL falling edge. `irq_tx` fires at the 9th SCL rising edge when `mode_dly`=0. When `mode_dly`=1 it fires at the first SCL falling edge after the 9th clock.
- R9: Each interrupt is a one-cycle pulse and at most one interrupt is high in any cycle. A pulse appears in the cycle after the (`filt_len`+3)th clock edge, counting as the first edge the one that first samples the pin change.
- R10: A change of any of `mode_en`, `mode_txrx` or `mode_dly` resets the bit count and cancels a pending delayed transmit event. No interrupt is high in the cycle after the change or while `mode_en` is 0.
- R11: `sda_out` follows `sda_init` only while `mode_en` is 0. While `mode_en` is 1 it holds its value.
- R12: `scl_rest` is 1 when `mode_dly`=0 and 0 when `mode_dly`=1.
- R13: `rx_valid` rises on a buffer load. While `rx_ready` is 0, `rx_valid` and `rx_data` hold until the next load, which overwrites the word. The word is taken, and `rx_valid` falls, at a clock edge where both `rx_valid` and `rx_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| filt_len | input | FILT_W | Glitch filter length in cycles |
| mode_en | input | 1 | Serial mode enable |
| mode_txrx | input | 1 | 0: ACK/NACK events, 1: receive/transmit events |
| mode_dly | input | 1 | 0: no clock delay, 1: with clock delay |
| sda_init | input | 1 | Starting level for the data output |
| sda_out | output | 1 | Data output level |
| scl_rest | output | 1 | Idle and final clock level |
| irq_ack | output | 1 | Acknowledge received pulse |
| irq_nack | output | 1 | No-acknowledge received pulse |
| irq_rx | output | 1 | Receive event pulse |
| irq_tx | output | 1 | Transmit event pulse |
| rx_data | output | 9 | Receive buffer word |
| rx_valid | output | 1 | Receive buffer holds an untaken word |
| rx_ready | input | 1 | Consumer takes the word |

## Verification
A pin change is caught by the first synchronizer flop at the edge that samples it. The filtered level moves `filt_len`+1 edges later. The sequencer registers the interrupt pulse one edge after that, and the buffer's `rx_valid` rises on the edge after the pulse. The bench drives pins and samples outputs on falling clock edges. In one directed case it checks that the pulse is absent one cycle early, present in the expected cycle and gone one cycle later, and that `rx_valid` follows one cycle behind. Frame-level results are counted by a falling-edge monitor and compared many cycles after the last bus edge, well beyond that latency.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int DATA_W = 8;
  localparam int WORD_W = DATA_W + 1;

  typedef struct packed {
    logic en;
    logic txrx;
    logic dly;
  } mode_t;

  // Build the receive word from the shifted byte (first bit in sh[7]).
  function automatic logic [WORD_W-1:0] pack_word(input logic split,
                                                   input logic [DATA_W-1:0] sh,
                                                   input logic ack);
    if (split) return {sh[0], ack, sh[DATA_W-1:1]};
    return {ack, sh};
  endfunction
endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_W = 4,
  parameter bit RST_VAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic [FILT_W-1:0] len_i,
  output logic              filt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_W-1:0]      run_q;
  logic [FILT_W-1:0]      run_nx;

  assign run_nx = run_q + FILT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{RST_VAL}};
      run_q  <= '0;
      filt_o <= RST_VAL;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      if (sync_q[SYNC_STAGES-1] != filt_o) begin
        if (run_nx >= len_i) begin
          filt_o <= sync_q[SYNC_STAGES-1];
          run_q  <= '0;
        end else begin
          run_q <= run_nx;
        end
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/i2c_bit_seq.sv
module i2c_bit_seq
  import i2c_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  mode_t             mode,
  output logic              ev_ack,
  output logic              ev_nack,
  output logic              ev_rx,
  output logic              ev_tx,
  output logic              ld,
  output logic [WORD_W-1:0] ld_data
);
  localparam int ACK_POS = DATA_W + 1;
  localparam int CNT_W = $clog2(ACK_POS + 1);

  mode_t             mode_q;
  logic              mode_chg;
  logic              scl_d;
  logic              rise, fall;
  logic              rise9, fall9, fall_next;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              ack_q;
  logic              pend_tx_q;
  logic              split;

  assign mode_chg  = (mode != mode_q);
  assign rise      = scl_f & ~scl_d;
  assign fall      = ~scl_f & scl_d;
  assign rise9     = rise && (cnt_q == CNT_W'(DATA_W));
  assign fall9     = fall && (cnt_q == CNT_W'(ACK_POS));
  assign fall_next = fall && (cnt_q == CNT_W'(1)) && pend_tx_q;
  assign split     = mode.txrx & mode.dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      scl_d     <= 1'b1;
      cnt_q     <= '0;
      sh_q      <= '0;
      ack_q     <= 1'b0;
      pend_tx_q <= 1'b0;
      ev_ack    <= 1'b0;
      ev_nack   <= 1'b0;
      ev_rx     <= 1'b0;
      ev_tx     <= 1'b0;
      ld        <= 1'b0;
      ld_data   <= '0;
    end else begin
      mode_q  <= mode;
      scl_d   <= scl_f;
      ev_ack  <= 1'b0;
      ev_nack <= 1'b0;
      ev_rx   <= 1'b0;
      ev_tx   <= 1'b0;
      ld      <= 1'b0;
      if (mode_chg || !mode.en) begin
        cnt_q     <= '0;
        pend_tx_q <= 1'b0;
      end else begin
        if (rise) begin
          cnt_q <= (cnt_q == CNT_W'(ACK_POS)) ? CNT_W'(1) : cnt_q + CNT_W'(1);
          if (cnt_q != CNT_W'(DATA_W)) sh_q <= {sh_q[DATA_W-2:0], sda_f};
          else                        ack_q <= sda_f;
        end
        if (rise9) begin
          ld      <= 1'b1;
          ld_data <= pack_word(split, sh_q, sda_f);
          if (!mode.txrx) begin
            ev_ack  <= ~sda_f;
            ev_nack <= sda_f;
          end else if (!mode.dly) begin
            ev_tx <= 1'b1;
          end
        end
        if (fall9) begin
          if (mode.dly) begin
            ld      <= 1'b1;
            ld_data <= pack_word(split, sh_q, ack_q);
          end
          if (mode.txrx) begin
            ev_rx <= 1'b1;
            if (mode.dly) pend_tx_q <= 1'b1;
          end
        end
        if (fall_next) begin
          ev_tx     <= 1'b1;
          pend_tx_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_rxbuf_stream.sv
module i2c_rxbuf_stream
  import i2c_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [WORD_W-1:0] ld_data,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (ld) begin
      rx_data  <= ld_data;
      rx_valid <= 1'b1;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_rx_event_ctrl.sv
module i2c_rx_event_ctrl
  import i2c_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [FILT_W-1:0] filt_len,
  input  logic              mode_en,
  input  logic              mode_txrx,
  input  logic              mode_dly,
  input  logic              sda_init,
  output logic              sda_out,
  output logic              scl_rest,
  output logic              irq_ack,
  output logic              irq_nack,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready
);
  localparam int NPINS = 2;
  localparam int PIN_SDA = 0;
  localparam int PIN_SCL = 1;

  logic [NPINS-1:0]  pin_raw;
  logic [NPINS-1:0]  pin_flt;
  mode_t             mode;
  logic              buf_ld;
  logic [WORD_W-1:0] buf_word;

  assign pin_raw = {scl_in, sda_in};
  assign mode    = '{en: mode_en, txrx: mode_txrx, dly: mode_dly};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    i2c_pin_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_W(FILT_W),
      .RST_VAL(1'b1)
    ) u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pin_raw[g]),
      .len_i (filt_len),
      .filt_o(pin_flt[g])
    );
  end

  i2c_bit_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_f  (pin_flt[PIN_SCL]),
    .sda_f  (pin_flt[PIN_SDA]),
    .mode   (mode),
    .ev_ack (irq_ack),
    .ev_nack(irq_nack),
    .ev_rx  (irq_rx),
    .ev_tx  (irq_tx),
    .ld     (buf_ld),
    .ld_data(buf_word)
  );

  i2c_rxbuf_stream u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (buf_ld),
    .ld_data (buf_word),
    .rx_data (rx_data),
    .rx_valid(rx_valid),
    .rx_ready(rx_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sda_out <= 1'b1;
    else if (!mode_en) sda_out <= sda_init;
  end

  assign scl_rest = ~mode_dly;
endmodule

// File: rtl/i2c_rx_event_chk.sv
module i2c_rx_event_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_en,
  input logic       mode_txrx,
  input logic       mode_dly,
  input logic       sda_out,
  input logic       irq_ack,
  input logic       irq_nack,
  input logic       irq_rx,
  input logic       irq_tx,
  input logic [8:0] rx_data,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       buf_ld
);
  p_irq_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ack, irq_nack, irq_rx, irq_tx}));

  p_rx_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |=> !irq_rx);

  p_tx_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |=> !irq_tx);

  p_ack_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack || irq_nack) |-> !$past(mode_txrx));

  p_txrx_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx || irq_tx) |-> $past(mode_txrx));

  p_mode_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ({mode_en, mode_txrx, mode_dly} != $past({mode_en, mode_txrx, mode_dly}))
      |=> !(irq_ack || irq_nack || irq_rx || irq_tx));

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !(irq_ack || irq_nack || irq_rx || irq_tx));

  p_sda_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && $past(mode_en)) |-> $stable(sda_out));

  p_buf_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !buf_ld) |=> (rx_valid && $stable(rx_data)));
endmodule

bind i2c_rx_event_ctrl i2c_rx_event_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_en  (mode_en),
  .mode_txrx(mode_txrx),
  .mode_dly (mode_dly),
  .sda_out  (sda_out),
  .irq_ack  (irq_ack),
  .irq_nack (irq_nack),
  .irq_rx   (irq_rx),
  .irq_tx   (irq_tx),
  .rx_data  (rx_data),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .buf_ld   (buf_ld)
);

// File: tb/test_i2c_rx_event_ctrl.sv
`timescale 1ns/1ps
module test_i2c_rx_event_ctrl;
  localparam int HP = 8;

  typedef struct packed {
    logic       txrx;
    logic       dly;
    logic [7:0] dat;
    logic       ack;
    logic [8:0] exp;
    logic [1:0] nld;
    logic [3:0] irq;   // {ack, nack, rx, tx}
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 1'b0, 8'hA5, 1'b0, 9'h0A5, 2'd1, 4'b1000},
    '{1'b0, 1'b0, 8'h3C, 1'b1, 9'h13C, 2'd1, 4'b0100},
    '{1'b1, 1'b0, 8'h96, 1'b0, 9'h096, 2'd1, 4'b0011},
    '{1'b0, 1'b1, 8'h5A, 1'b1, 9'h15A, 2'd2, 4'b0100},
    '{1'b1, 1'b1, 8'hC3, 1'b0, 9'h161, 2'd2, 4'b0011},
    '{1'b1, 1'b1, 8'h81, 1'b1, 9'h1C0, 2'd2, 4'b0011}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1;
  logic [3:0] filt_len = 4'd3;
  logic       mode_en = 1'b0, mode_txrx = 1'b0, mode_dly = 1'b0;
  logic       sda_init = 1'b1;
  logic       rx_ready = 1'b1;
  logic       sda_out, scl_rest, irq_ack, irq_nack, irq_rx, irq_tx, rx_valid;
  logic [8:0] rx_data;

  int n_chk = 0, n_err = 0;
  int m_ack = 0, m_nack = 0, m_rx = 0, m_tx = 0, m_ld = 0;
  logic [8:0] m_data = '0;

  always #5 clk = ~clk;

  i2c_rx_event_ctrl i_i2c_rx_event_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .filt_len(filt_len),
    .mode_en(mode_en), .mode_txrx(mode_txrx), .mode_dly(mode_dly),
    .sda_init(sda_init), .sda_out(sda_out), .scl_rest(scl_rest),
    .irq_ack(irq_ack), .irq_nack(irq_nack), .irq_rx(irq_rx), .irq_tx(irq_tx),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  always @(negedge clk) begin
    if (irq_ack)  m_ack++;
    if (irq_nack) m_nack++;
    if (irq_rx)   m_rx++;
    if (irq_tx)   m_tx++;
    if (rx_valid && rx_ready) begin
      m_ld++;
      m_data = rx_data;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic en, input logic txrx, input logic dly);
    @(negedge clk);
    mode_en = en; mode_txrx = txrx; mode_dly = dly; scl = 1'b0;
    wait_n(HP);
  endtask

  task automatic clk_bit(input logic b);
    @(negedge clk);
    sda = b;
    wait_n(HP);
    scl = 1'b1;
    wait_n(HP);
    scl = 1'b0;
    wait_n(HP);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic a);
    for (int i = 7; i >= 0; i--) clk_bit(d[i]);
    clk_bit(a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int b_ack, b_nack, b_rx, b_tx, b_ld;
    wait_n(5);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {irq_ack, irq_nack, irq_rx, irq_tx}, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 sda_out", sda_out, 1);

    // R12 resting clock level
    set_mode(1'b0, 1'b0, 1'b0);
    chk("R12 no delay", scl_rest, 1);
    set_mode(1'b0, 1'b0, 1'b1);
    chk("R12 delay", scl_rest, 0);

    // R11 starting SDA value only while disabled
    sda_init = 1'b0;
    wait_n(3);
    chk("R11 load while off", sda_out, 0);
    set_mode(1'b1, 1'b0, 1'b0);
    sda_init = 1'b1;
    wait_n(3);
    chk("R11 hold while on", sda_out, 0);

    // Vector table: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < 6; v++) begin
      set_mode(1'b0, VEC[v].txrx, VEC[v].dly);
      set_mode(1'b1, VEC[v].txrx, VEC[v].dly);
      b_ack = m_ack; b_nack = m_nack; b_rx = m_rx; b_tx = m_tx; b_ld = m_ld;
      send_frame(VEC[v].dat, VEC[v].ack);
      clk_bit(1'b1);
      wait_n(HP);
      chk("R3 R7 word", m_data, VEC[v].exp);
      chk("R5 R6 loads", m_ld - b_ld, VEC[v].nld);
      chk("R4 R8 irq", {4'(m_ack - b_ack), 4'(m_nack - b_nack), 4'(m_rx - b_rx), 4'(m_tx - b_tx)},
          {3'd0, VEC[v].irq[3], 3'd0, VEC[v].irq[2], 3'd0, VEC[v].irq[1], 3'd0, VEC[v].irq[0]});
    end

    // R2 glitch on SCL shorter than filt_len is ignored
    set_mode(1'b0, 1'b0, 1'b0);
    set_mode(1'b1, 1'b0, 1'b0);
    b_ack = m_ack;
    @(negedge clk); scl = 1'b1;
    wait_n(2); scl = 1'b0;
    wait_n(HP);
    send_frame(8'hA5, 1'b0);
    wait_n(HP);
    chk("R2 word after glitch", m_data, 9'h0A5);
    chk("R2 ack count", m_ack - b_ack, 1);

    // R10 mode change cancels a pending delayed transmit event
    set_mode(1'b0, 1'b1, 1'b1);
    set_mode(1'b1, 1'b1, 1'b1);
    send_frame(8'hC3, 1'b0);
    set_mode(1'b0, 1'b1, 1'b1);
    set_mode(1'b1, 1'b1, 1'b1);
    b_tx = m_tx;
    clk_bit(1'b1);
    wait_n(HP);
    chk("R10 tx cancelled", m_tx - b_tx, 0);

    // R9 exact pulse timing, filt_len = 2
    filt_len = 4'd2;
    set_mode(1'b0, 1'b0, 1'b0);
    set_mode(1'b1, 1'b0, 1'b0);
    for (int i = 7; i >= 0; i--) clk_bit(1'b0);
    @(negedge clk); sda = 1'b0;
    wait_n(HP);
    scl = 1'b1;
    wait_n(4);
    chk("R9 pulse not early", irq_ack, 0);
    @(negedge clk);
    chk("R9 pulse due", irq_ack, 1);
    @(negedge clk);
    chk("R9 pulse single", irq_ack, 0);
    chk("R13 valid after load", rx_valid, 1);
    wait_n(HP);
    scl = 1'b0;
    wait_n(HP);

    // R13 back-pressure and overwrite
    filt_len = 4'd3;
    set_mode(1'b0, 1'b0, 1'b0);
    set_mode(1'b1, 1'b0, 1'b0);
    rx_ready = 1'b0;
    send_frame(8'h5A, 1'b0);
    wait_n(20);
    chk("R13 held valid", rx_valid, 1);
    chk("R13 held word", rx_data, 9'h05A);
    send_frame(8'h3C, 1'b1);
    wait_n(HP);
    chk("R13 overwrite", rx_data, 9'h13C);
    #1 rx_ready = 1'b1;
    wait_n(2);
    chk("R13 taken", rx_valid, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule